// File: doc/BRIEF.md
# I2C Master Address Sequencer and Receive Byte Counter

This block runs the address phase of an I2C master and then keeps a count of the data bytes that come back during a read. Software writes two address byte registers. On a start request the block offers the first byte to a bit-level shifter. The first byte holds either a 7-bit address with its direction bit or a 10-bit header. When the shifter reports that byte as acknowledged, the block looks at the upper five bits of the first byte. If they form the 10-bit header tag, it offers the second byte. Otherwise it goes straight to the data phase.

In the data phase every byte-received pulse from the shifter adds one to an 8-bit count. The count wraps, so a 256-byte read leaves it at zero. A missing acknowledge on either address byte ends the address phase, sets a NACK flag and stops any further byte requests. A stop request returns the block to idle and the count keeps its value.

Top module: `i2c_addr_rxcount`

## Requirements
- R1: After a synchronous reset, both address byte registers read 0x00, `rx_count` is 0, and `tx_valid`, `rx_active` and `nack` are 0.
- R2: A cycle with `reg_wr` high loads `reg_wdata` into the first address byte when `reg_sel` is 0, and into the second when `reg_sel` is 1. The new value appears on `hdr_q` or `ext_q` after the next clock edge.
- R3: The cycle after `start` is sampled, `tx_valid` is 1 and `tx_byte` equals the first address byte.
- R4: When the first byte is acknowledged (`tx_done` high with `tx_ack` high) and its bits 7..3 are not 11110, no second byte is offered. The next cycle has `tx_valid` 0 and `rx_active` 1.
- R5: When the first byte is acknowledged and its bits 7..3 are 11110, the next cycle has `tx_valid` 1 and `tx_byte` equal to the second address byte. Acknowledging that byte moves the block to the data phase (`rx_active` 1).
- R6: A `tx_done` with `tx_ack` low on either address byte sets `nack` to 1 and drops `tx_valid` to 0 on the next cycle. No further byte is offered until the next `start`.
- R7: `rx_count` increases by exactly one for each cycle with `rx_done` high while `rx_active` is 1. `rx_done` has no effect on `rx_count` at any other time.
- R8: `rx_count` is 8 bits wide and wraps. After 256 received bytes it reads 0, and after 255 it reads 0xFF.
- R9: `start` clears `rx_count` and `nack` to 0 on the next cycle, from any state, including the middle of a data phase.
- R10: `stop` returns the block to idle (`rx_active` and `tx_valid` 0), and `rx_count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Address byte register write strobe |
| reg_sel | input | 1 | Register select: 0 first byte, 1 second byte |
| reg_wdata | input | 8 | Register write data |
| hdr_q | output | 8 | First address byte readback |
| ext_q | output | 8 | Second address byte readback |
| start | input | 1 | Begin a transfer (address phase) |
| stop | input | 1 | End the transfer, return to idle |
| tx_valid | output | 1 | A byte is offered to the shifter |
| tx_byte | output | 8 | Byte offered to the shifter |
| tx_done | input | 1 | Shifter finished sending the offered byte |
| tx_ack | input | 1 | Acknowledge level seen for that byte, valid with tx_done |
| rx_done | input | 1 | Shifter finished receiving a data byte |
| rx_active | output | 1 | Data phase in progress |
| nack | output | 1 | An address byte was not acknowledged |
| rx_count | output | 8 | Bytes received in the current transfer |

## Verification
A wrong sequencer state shows up on `tx_valid`, `tx_byte`, `rx_active` or `nack` on the first cycle after the `tx_done` that should have moved it. A 10-bit header that is taken for a 7-bit address skips the second byte. An unacknowledged byte that is treated as acknowledged leaves `nack` low. A counter fault shows up on `rx_count` one cycle after the `rx_done` concerned. Faults of this kind include a missed clear on `start`, counting outside the data phase, or saturating instead of wrapping. The bench model is compared against every output on every clock, so each of these faults is reported within one cycle of the stimulus that exposes it.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_EXT  = 2'd2,
    ST_DATA = 2'd3
  } am_state_t;

  localparam int unsigned TAG_W = 5;
  localparam logic [TAG_W-1:0] LONG_TAG = 5'b11110;
endpackage

// File: rtl/i2c_am_regs.sv
module i2c_am_regs #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NREG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [$clog2(NREG)-1:0] sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] q [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[g] <= '0;
      else if (wr && sel == g) q[g] <= wdata;
    end

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
      (wr && sel == g) |=> q[g] == $past(wdata)); // R2
    AST_REG_KEEP: assert property (@(posedge clk) disable iff (rst)
      !(wr && sel == g) |=> $stable(q[g])); // R2
  end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              tx_done,
  input  logic              tx_ack,
  input  logic [BYTE_W-1:0] hdr,
  output logic              tx_valid,
  output logic              sel_ext,
  output logic              rx_active,
  output logic              nack
);
  am_state_t state, nxt;
  logic      long_addr;
  logic      nack_nxt;

  assign long_addr = (hdr[BYTE_W-1 -: TAG_W] == LONG_TAG);

  always_comb begin
    nxt      = state;
    nack_nxt = nack;
    if (start) begin
      nxt      = ST_HDR;
      nack_nxt = 1'b0;
    end else if (stop) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_HDR: if (tx_done) begin
          if (!tx_ack) begin
            nxt      = ST_IDLE;
            nack_nxt = 1'b1;
          end else begin
            nxt = long_addr ? ST_EXT : ST_DATA;
          end
        end
        ST_EXT: if (tx_done) begin
          if (!tx_ack) begin
            nxt      = ST_IDLE;
            nack_nxt = 1'b1;
          end else begin
            nxt = ST_DATA;
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tx_valid  <= 1'b0;
      sel_ext   <= 1'b0;
      rx_active <= 1'b0;
      nack      <= 1'b0;
    end else begin
      state     <= nxt;
      tx_valid  <= (nxt == ST_HDR) || (nxt == ST_EXT);
      sel_ext   <= (nxt == ST_EXT);
      rx_active <= (nxt == ST_DATA);
      nack      <= nack_nxt;
    end
  end

  AST_START_OFFERS: assert property (@(posedge clk) disable iff (rst)
    start |=> tx_valid && !sel_ext && !nack); // R3
  AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && tx_done && tx_ack && !long_addr && !start && !stop)
      |=> rx_active && !tx_valid); // R4
  AST_LONG_ADDR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && tx_done && tx_ack && long_addr && !start && !stop)
      |=> tx_valid && sel_ext); // R5
  AST_NACK_HALTS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_done && !tx_ack && !start && !stop)
      |=> nack && !tx_valid && !rx_active); // R6
  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (nack && !start) |=> nack && !tx_valid); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !tx_valid && !rx_active); // R10
endmodule

// File: rtl/i2c_am_rxcnt.sv
module i2c_am_rxcnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt)); // R7
endmodule

// File: rtl/i2c_addr_rxcount.sv
module i2c_addr_rxcount #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] hdr_q,
  output logic [BYTE_W-1:0] ext_q,
  input  logic              start,
  input  logic              stop,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_done,
  input  logic              tx_ack,
  input  logic              rx_done,
  output logic              rx_active,
  output logic              nack,
  output logic [CNT_W-1:0]  rx_count
);
  localparam int unsigned NREG = 2;

  logic [BYTE_W-1:0] addr_q [NREG];
  logic              sel_ext;
  logic              cnt_en;

  i2c_am_regs #(.BYTE_W(BYTE_W), .NREG(NREG)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .q     (addr_q)
  );

  assign hdr_q = addr_q[0];
  assign ext_q = addr_q[1];

  i2c_am_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .tx_done   (tx_done),
    .tx_ack    (tx_ack),
    .hdr       (addr_q[0]),
    .tx_valid  (tx_valid),
    .sel_ext   (sel_ext),
    .rx_active (rx_active),
    .nack      (nack)
  );

  assign tx_byte = sel_ext ? addr_q[1] : addr_q[0];
  assign cnt_en  = rx_active && rx_done && !start;

  i2c_am_rxcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .en  (cnt_en),
    .cnt (rx_count)
  );

  AST_IDLE_IGNORES_RX: assert property (@(posedge clk) disable iff (rst)
    (!rx_active && !start) |=> $stable(rx_count)); // R7
  AST_OFFER_IS_HDR: assert property (@(posedge clk) disable iff (rst)
    start |=> tx_byte == hdr_q); // R3
endmodule

// File: tb/i2c_addr_rxcount_test.sv
module i2c_addr_rxcount_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       start = 1'b0, stop = 1'b0;
  logic       tx_done = 1'b0, tx_ack = 1'b0, rx_done = 1'b0;
  logic [7:0] hdr_q, ext_q, tx_byte, rx_count;
  logic       tx_valid, rx_active, nack;

  int checks = 0;
  int errors = 0;
  int cyc_n  = 0;

  // reference model: 0 idle, 1 first byte, 2 second byte, 3 data
  int m_st = 0, m_hdr = 0, m_ext = 0, m_cnt = 0, m_nack = 0;

  always #4 clk = ~clk;

  i2c_addr_rxcount uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .hdr_q(hdr_q), .ext_q(ext_q),
    .start(start), .stop(stop), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_done(tx_done), .tx_ack(tx_ack), .rx_done(rx_done),
    .rx_active(rx_active), .nack(nack), .rx_count(rx_count)
  );

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (rst) begin
      m_st = 0; m_hdr = 0; m_ext = 0; m_cnt = 0; m_nack = 0;
    end else begin
      if (start) begin
        m_st = 1; m_cnt = 0; m_nack = 0;
      end else if (stop) begin
        m_st = 0;
      end else if (m_st == 1 && tx_done) begin
        if (!tx_ack) begin m_st = 0; m_nack = 1; end
        else if ((m_hdr / 8) == 30) m_st = 2;
        else m_st = 3;
      end else if (m_st == 2 && tx_done) begin
        if (!tx_ack) begin m_st = 0; m_nack = 1; end
        else m_st = 3;
      end else if (m_st == 3 && rx_done) begin
        m_cnt = (m_cnt + 1) % 256;
      end
      if (reg_wr) begin
        if (reg_sel) m_ext = int'(reg_wdata);
        else m_hdr = int'(reg_wdata);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cyc_n > 0) begin
      chk("R2 hdr_q", int'(hdr_q), m_hdr);
      chk("R2 ext_q", int'(ext_q), m_ext);
      chk("R3 tx_valid", int'(tx_valid), int'(m_st == 1 || m_st == 2));
      if (m_st == 1) chk("R3 tx_byte", int'(tx_byte), m_hdr);
      if (m_st == 2) chk("R5 tx_byte", int'(tx_byte), m_ext);
      chk("R4 rx_active", int'(rx_active), int'(m_st == 3));
      chk("R6 nack", int'(nack), m_nack);
      chk("R7 rx_count", int'(rx_count), m_cnt);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic send_done(input logic ack);
    tx_done = 1'b1; tx_ack = ack; step(); tx_done = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic rx_bytes(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      rx_done = 1'b1; step(); rx_done = 1'b0;
      if (gaps) step();
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 hdr", int'(hdr_q), 0);
    chk("R1 ext", int'(ext_q), 0);
    chk("R1 count", int'(rx_count), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 nack", int'(nack), 0);
    chk("R1 rx_active", int'(rx_active), 0);

    // R2 register writes
    wr_reg(1'b0, 8'hA1);
    wr_reg(1'b1, 8'h3C);
    chk("R2 hdr write", int'(hdr_q), 'hA1);
    chk("R2 ext write", int'(ext_q), 'h3C);

    // R3 / R4 seven-bit read
    pulse_start();
    chk("R3 offer valid", int'(tx_valid), 1);
    chk("R3 offer byte", int'(tx_byte), 'hA1);
    step();
    chk("R3 offer held", int'(tx_valid), 1);
    send_done(1'b1);
    chk("R4 no second byte", int'(tx_valid), 0);
    chk("R4 data phase", int'(rx_active), 1);

    // R7 counting with gaps
    rx_bytes(5, 1'b1);
    chk("R7 five bytes", int'(rx_count), 5);

    // R10 stop holds count; R7 ignore outside data phase
    stop = 1'b1; step(); stop = 1'b0;
    chk("R10 idle", int'(rx_active), 0);
    chk("R10 count held", int'(rx_count), 5);
    rx_bytes(3, 1'b0);
    chk("R7 idle rx ignored", int'(rx_count), 5);

    // R5 ten-bit header 11110_01_0
    wr_reg(1'b0, 8'hF2);
    pulse_start();
    chk("R9 count cleared", int'(rx_count), 0);
    chk("R3 header offered", int'(tx_byte), 'hF2);
    send_done(1'b1);
    chk("R5 second valid", int'(tx_valid), 1);
    chk("R5 second byte", int'(tx_byte), 'h3C);
    rx_bytes(2, 1'b0);
    chk("R7 rx during address ignored", int'(rx_count), 0);
    send_done(1'b1);
    chk("R5 data phase", int'(rx_active), 1);
    rx_bytes(2, 1'b0);
    chk("R7 two bytes", int'(rx_count), 2);

    // R6 nack on second byte
    pulse_start();
    send_done(1'b1);
    send_done(1'b0);
    chk("R6 nack second", int'(nack), 1);
    chk("R6 no offer", int'(tx_valid), 0);
    step(); step();
    chk("R6 stays halted", int'(tx_valid), 0);

    // R6 nack on first (7-bit write) then R9 clear
    wr_reg(1'b0, 8'h90);
    pulse_start();
    chk("R9 nack cleared", int'(nack), 0);
    send_done(1'b0);
    chk("R6 nack first", int'(nack), 1);
    chk("R6 no data phase", int'(rx_active), 0);

    // R8 wrap at 256
    wr_reg(1'b0, 8'hA1);
    pulse_start();
    send_done(1'b1);
    rx_bytes(255, 1'b0);
    chk("R8 255 bytes", int'(rx_count), 'hFF);
    rx_bytes(1, 1'b0);
    chk("R8 256 wraps", int'(rx_count), 0);
    rx_bytes(3, 1'b0);
    chk("R8 after wrap", int'(rx_count), 3);

    // R9 restart mid data phase
    pulse_start();
    chk("R9 restart clears", int'(rx_count), 0);
    chk("R9 restart offers", int'(tx_valid), 1);
    // 10-bit tag ignored for a 7-bit pattern 11110 only in top bits: 0xF0 is long
    wr_reg(1'b0, 8'hF0);
    send_done(1'b1);
    chk("R5 tag F0 long", int'(tx_valid), 1);
    send_done(1'b1);
    chk("R5 then data", int'(rx_active), 1);

    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule